// File: doc/BRIEF.md
# Per-Context Jitter Buffer Playout Controller

This block sits on the receive side of a packet-to-TDM path and serves one context. Packets arriving from the network are written into a small internal queue, and a constant-rate playout side takes them out again, one packet per playout slot. The queue absorbs packet delay variation, so the constant-rate output sees a steady supply even when packets arrive unevenly.

The initial latency is set by time rather than by fill level. After a context is armed, the first accepted packet starts a countdown of a programmed number of 125 µs frame periods. The countdown advances on a frame-pulse input. Reads begin only when it runs out. From then on the queue depth is free to drift. Each playout strobe either delivers the oldest packet or, when the queue is empty, delivers an all-ones fill word and reports starvation. A packet that arrives while the queue is full is dropped. Both error kinds latch into sticky flags that stay set until software clears them. A context reset empties the queue and re-arms the start delay.

Top module: `jbuf_playout_ctrl`

## Requirements
- R1: After reset, `fill_level` is 0, and `playing`, `slot_valid`, `slot_starved`, `ovf_flag` and `unf_flag` are all 0.
- R2: A write with `wr_valid` high, when the queue is not full and `ctx_clear` is low, is accepted. Occupancy then rises by one unless a read happens in the same cycle, and packets are read out in arrival order.
- R3: A write that arrives while `fill_level` equals the queue depth (8 by default) is dropped. The stored packets are kept and `ovf_flag` is set on the next cycle. Fullness is judged on the occupancy before that cycle, even if a read happens in the same cycle.
- R4: The first write accepted after arming starts a hold of `start_frames` frame periods, with `start_frames` sampled at that write. Frame ticks are counted from the cycle after that write. `playing` rises in the cycle after the edge that sees the last counted tick. With `start_frames` = 0, `playing` rises in the cycle after the first write.
- R5: While `playing` is low, `play_strobe` has no effect: no slot output appears and occupancy does not change.
- R6: While `playing` is high, a `play_strobe` that finds occupancy above 0 gives `slot_valid` = 1 in the next cycle. In that cycle `slot_data` holds the oldest packet, and the packet leaves the queue.
- R7: While `playing` is high, a `play_strobe` that finds the queue empty gives `slot_starved` = 1 and `slot_data` = all ones in the next cycle. `unf_flag` is set, and occupancy is not decremented.
- R8: `ovf_flag` and `unf_flag` stay set until `err_clear` is pulsed. A new error event in the same cycle as `err_clear` wins, so the flag stays set.
- R9: `ctx_clear` makes `fill_level` 0 and `playing` 0 on the next cycle, and discards any write or strobe in the same cycle. It leaves the sticky flags alone, and the next first packet waits the full programmed delay again.
- R10: `slot_valid` and `slot_starved` are never high together, and either one is high only in the cycle after a `play_strobe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctx_clear | input | 1 | Context reset: empty queue, re-arm start delay |
| start_frames | input | FRAME_W | Initial hold in 125 µs frame periods |
| frame_tick | input | 1 | One-cycle pulse at each frame boundary |
| wr_valid | input | 1 | Packet arrival strobe |
| wr_data | input | DATA_W | Arriving packet word |
| play_strobe | input | 1 | Playout slot request |
| err_clear | input | 1 | Clears both sticky error flags |
| slot_valid | output | 1 | Slot delivered a stored packet |
| slot_starved | output | 1 | Slot found the queue empty |
| slot_data | output | DATA_W | Packet for the slot, or all ones on starvation |
| fill_level | output | ADDR_W+1 | Packets currently held |
| playing | output | 1 | Start delay has expired and reads are enabled |
| ovf_flag | output | 1 | Sticky overflow |
| unf_flag | output | 1 | Sticky underrun |

## Verification
On every cycle the assertions check several properties. A write into a full queue must raise the overflow flag. A strobe before playout must produce no output. A strobe on an empty queue while playing must yield the fill word and the underrun flag, and a strobe on a non-empty queue must yield a valid slot. The sticky flags must not drop without a clear, a context reset must empty the queue, and the two slot outputs must stay exclusive. The bench scenarios show what no single-cycle property can: packets come out in arrival order after overflow and read traffic, the hold lasts exactly the programmed number of frame ticks, and a re-armed context waits the full delay again. A cycle-level bench model checks all of this under mixed random traffic.

// File: rtl/jbuf_pkg.sv
package jbuf_pkg;

  typedef enum logic [1:0] {
    GATE_ARMED = 2'd0,
    GATE_HOLD  = 2'd1,
    GATE_PLAY  = 2'd2
  } gate_state_e;

  // Occupancy after one cycle of accepted pushes and pops.
  function automatic int occ_next(int occ, logic push, logic pop);
    if (push && !pop) return occ + 1;
    if (pop && !push) return occ - 1;
    return occ;
  endfunction

  // The hold ends on the tick that sees the last remaining frame.
  function automatic logic hold_expires(int frames_left, logic tick);
    return tick && (frames_left == 1);
  endfunction

endpackage

// File: rtl/jbuf_fifo.sv
module jbuf_fifo #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] push_data,
  output logic [DATA_W-1:0] head_data,
  output logic [ADDR_W:0]   count,
  output logic              empty,
  output logic              full
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CNT_W = ADDR_W + 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  count_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (push && wr_ptr == ADDR_W'(i)) mem[i] <= push_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_q <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      count_q <= CNT_W'(jbuf_pkg::occ_next(int'(count_q), push, pop));
    end
  end

  assign head_data = mem[rd_ptr];
  assign count     = count_q;
  assign empty     = (count_q == '0);
  assign full      = (count_q == CNT_W'(DEPTH));
endmodule

// File: rtl/jbuf_start_gate.sv
module jbuf_start_gate #(
  parameter int FRAME_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               first_fill,
  input  logic               frame_tick,
  input  logic [FRAME_W-1:0] start_frames,
  output logic               gate_open,
  output logic               holding,
  output logic               playing
);
  import jbuf_pkg::*;

  gate_state_e        state_q;
  logic [FRAME_W-1:0] frames_left_q;
  logic               open_now, expire;

  assign expire = hold_expires(int'(frames_left_q), frame_tick);

  always_comb begin
    open_now = 1'b0;
    if (!clear) begin
      if (state_q == GATE_ARMED && first_fill && start_frames == '0) open_now = 1'b1;
      if (state_q == GATE_HOLD && expire) open_now = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      state_q       <= GATE_ARMED;
      frames_left_q <= '0;
    end else begin
      unique case (state_q)
        GATE_ARMED: if (first_fill) begin
          if (start_frames == '0) state_q <= GATE_PLAY;
          else begin
            state_q       <= GATE_HOLD;
            frames_left_q <= start_frames;
          end
        end
        GATE_HOLD: if (frame_tick) begin
          if (expire) state_q <= GATE_PLAY;
          else        frames_left_q <= frames_left_q - 1'b1;
        end
        GATE_PLAY: state_q <= GATE_PLAY;
        default:   state_q <= GATE_ARMED;
      endcase
    end
  end

  assign gate_open = open_now;
  assign holding   = (state_q == GATE_HOLD);
  assign playing   = (state_q == GATE_PLAY);
endmodule

// File: rtl/jbuf_sticky.sv
module jbuf_sticky #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic         clr,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)      flags[i] <= 1'b0;
      else if (set[i]) flags[i] <= 1'b1;
      else if (clr)    flags[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/jbuf_playout_ctrl.sv
module jbuf_playout_ctrl #(
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 3,
  parameter int FRAME_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctx_clear,
  input  logic [FRAME_W-1:0] start_frames,
  input  logic               frame_tick,
  input  logic               wr_valid,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               play_strobe,
  input  logic               err_clear,
  output logic               slot_valid,
  output logic               slot_starved,
  output logic [DATA_W-1:0]  slot_data,
  output logic [ADDR_W:0]    fill_level,
  output logic               playing,
  output logic               ovf_flag,
  output logic               unf_flag
);
  localparam int ERR_N   = 2;
  localparam int ERR_OVF = 0;
  localparam int ERR_UNF = 1;

  // Named internal events.
  logic              q_empty, q_full;
  logic [DATA_W-1:0] head_data;
  logic              push_ok, push_drop;
  logic              slot_due, slot_pop, slot_starve;
  logic              gate_open, holding;
  logic [ERR_N-1:0]  err_set, err_flags;

  assign push_ok     = wr_valid && !q_full && !ctx_clear;
  assign push_drop   = wr_valid &&  q_full && !ctx_clear;
  assign slot_due    = playing && play_strobe && !ctx_clear;
  assign slot_pop    = slot_due && !q_empty;
  assign slot_starve = slot_due &&  q_empty;

  jbuf_fifo #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (ctx_clear),
    .push      (push_ok),
    .pop       (slot_pop),
    .push_data (wr_data),
    .head_data (head_data),
    .count     (fill_level),
    .empty     (q_empty),
    .full      (q_full)
  );

  jbuf_start_gate #(.FRAME_W(FRAME_W)) u_gate (
    .clk          (clk),
    .rst_n        (rst_n),
    .clear        (ctx_clear),
    .first_fill   (push_ok),
    .frame_tick   (frame_tick),
    .start_frames (start_frames),
    .gate_open    (gate_open),
    .holding      (holding),
    .playing      (playing)
  );

  assign err_set[ERR_OVF] = push_drop;
  assign err_set[ERR_UNF] = slot_starve;

  jbuf_sticky #(.N(ERR_N)) u_err (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (err_set),
    .clr   (err_clear),
    .flags (err_flags)
  );

  assign ovf_flag = err_flags[ERR_OVF];
  assign unf_flag = err_flags[ERR_UNF];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_valid   <= 1'b0;
      slot_starved <= 1'b0;
      slot_data    <= '0;
    end else begin
      slot_valid   <= slot_pop;
      slot_starved <= slot_starve;
      if (slot_pop)         slot_data <= head_data;
      else if (slot_starve) slot_data <= '1;
      else                  slot_data <= '0;
    end
  end
endmodule

// File: rtl/jbuf_playout_ctrl_chk.sv
module jbuf_playout_ctrl_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ctx_clear,
  input logic              wr_valid,
  input logic              play_strobe,
  input logic              err_clear,
  input logic              slot_valid,
  input logic              slot_starved,
  input logic [DATA_W-1:0] slot_data,
  input logic [ADDR_W:0]   fill_level,
  input logic              playing,
  input logic              ovf_flag,
  input logic              unf_flag,
  input logic              push_drop,
  input logic              slot_starve
);
  localparam int DEPTH = 1 << ADDR_W;

  p_occ_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fill_level <= (ADDR_W+1)'(DEPTH));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && fill_level == (ADDR_W+1)'(DEPTH) && !ctx_clear) |=> ovf_flag);

  p_hold_ignores_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!playing && play_strobe) |=> (!slot_valid && !slot_starved));

  p_read_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (playing && play_strobe && !ctx_clear && fill_level != '0) |=> slot_valid);

  p_underrun_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (playing && play_strobe && !ctx_clear && fill_level == '0)
      |=> (slot_starved && slot_data == '1 && unf_flag));

  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !err_clear) |=> ovf_flag);

  p_unf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (unf_flag && !err_clear) |=> unf_flag);

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (push_drop || slot_starve) |=> (ovf_flag || unf_flag));

  p_clear_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_clear |=> (fill_level == '0 && !playing));

  p_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(slot_valid && slot_starved));

  p_only_on_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_valid || slot_starved) |-> $past(play_strobe));
endmodule

bind jbuf_playout_ctrl jbuf_playout_ctrl_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ctx_clear    (ctx_clear),
  .wr_valid     (wr_valid),
  .play_strobe  (play_strobe),
  .err_clear    (err_clear),
  .slot_valid   (slot_valid),
  .slot_starved (slot_starved),
  .slot_data    (slot_data),
  .fill_level   (fill_level),
  .playing      (playing),
  .ovf_flag     (ovf_flag),
  .unf_flag     (unf_flag),
  .push_drop    (push_drop),
  .slot_starve  (slot_starve)
);

// File: tb/jbuf_playout_ctrl_bench.sv
`timescale 1ns/1ps
module jbuf_playout_ctrl_bench;
  localparam int DATA_W  = 16;
  localparam int ADDR_W  = 3;
  localparam int FRAME_W = 8;
  localparam int DEPTH   = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctx_clear = 0, frame_tick = 0, wr_valid = 0, play_strobe = 0, err_clear = 0;
  logic [FRAME_W-1:0] start_frames = '0;
  logic [DATA_W-1:0]  wr_data = '0;
  logic slot_valid, slot_starved, playing, ovf_flag, unf_flag;
  logic [DATA_W-1:0] slot_data;
  logic [ADDR_W:0]   fill_level;

  always #2 clk = ~clk;

  jbuf_playout_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .FRAME_W(FRAME_W)) u_jbuf_playout_ctrl (
    .clk(clk), .rst_n(rst_n), .ctx_clear(ctx_clear), .start_frames(start_frames),
    .frame_tick(frame_tick), .wr_valid(wr_valid), .wr_data(wr_data),
    .play_strobe(play_strobe), .err_clear(err_clear), .slot_valid(slot_valid),
    .slot_starved(slot_starved), .slot_data(slot_data), .fill_level(fill_level),
    .playing(playing), .ovf_flag(ovf_flag), .unf_flag(unf_flag)
  );

  int checks = 0;
  int fails  = 0;

  // Reference model state, written from the requirements.
  int mq[$];
  int mst  = 0;   // 0 armed, 1 hold, 2 play
  int mcnt = 0;
  bit movf = 0, munf = 0;
  bit ev = 0, es = 0;
  int ed = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int fill_word();
    return (1 << DATA_W) - 1;
  endfunction

  function automatic int next_gate(int st, bit acc, bit tick, int sf, ref int cnt);
    if (st == 0 && acc) begin
      if (sf == 0) return 2;
      cnt = sf;
      return 1;
    end
    if (st == 1 && tick) begin
      if (cnt == 1) return 2;
      cnt = cnt - 1;
    end
    return st;
  endfunction

  task automatic model(bit clr, bit wv, int wd, bit ps, bit ft, bit ec, int sf);
    bit ovs, uns, due, emp, ful, acc;
    ovs = 0; uns = 0;
    if (clr) begin
      mq.delete(); mst = 0; mcnt = 0; ev = 0; es = 0; ed = 0;
    end else begin
      due = (mst == 2) && ps;
      emp = (mq.size() == 0);
      ful = (mq.size() == DEPTH);
      ev  = due && !emp;
      es  = due && emp;
      ed  = ev ? mq[0] : (es ? fill_word() : 0);
      acc = wv && !ful;
      ovs = wv && ful;
      uns = es;
      if (ev) void'(mq.pop_front());
      if (acc) mq.push_back(wd);
      mst = next_gate(mst, acc, ft, sf, mcnt);
    end
    movf = ovs || (movf && !ec);
    munf = uns || (munf && !ec);
  endtask

  task automatic compare();
    chk(int'(fill_level) == mq.size(), "R2 fill_level", int'(fill_level), mq.size());
    chk(playing == (mst == 2), "R4 playing", int'(playing), int'(mst == 2));
    chk(slot_valid == ev, "R6 slot_valid", int'(slot_valid), int'(ev));
    chk(slot_starved == es, "R7 slot_starved", int'(slot_starved), int'(es));
    if (ev || es) chk(int'(slot_data) == ed, "R6 slot_data", int'(slot_data), ed);
    chk(ovf_flag == movf, "R3 ovf_flag", int'(ovf_flag), int'(movf));
    chk(unf_flag == munf, "R8 unf_flag", int'(unf_flag), int'(munf));
    chk(!(slot_valid && slot_starved), "R10 exclusive", int'(slot_valid && slot_starved), 0);
  endtask

  task automatic step(bit clr, bit wv, int wd, bit ps, bit ft, bit ec);
    @(negedge clk);
    ctx_clear = clr; wr_valid = wv; wr_data = DATA_W'(wd);
    play_strobe = ps; frame_tick = ft; err_clear = ec;
    @(posedge clk);
    #1;
    model(clr, wv, wd, ps, ft, ec, int'(start_frames));
    compare();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0);
  endtask

  bit done = 0;

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #0;
    // R1: reset state
    chk(fill_level == '0 && !playing && !slot_valid && !slot_starved && !ovf_flag && !unf_flag,
        "R1 reset state", int'(fill_level), 0);

    // R4/R5: hold of three frames
    start_frames = 8'd3;
    step(0, 1, 16'h0A01, 0, 0, 0);
    step(0, 1, 16'h0A02, 1, 1, 0);   // strobe during hold, tick 1
    chk(!slot_valid && !slot_starved && fill_level == 2, "R5 strobe ignored", int'(fill_level), 2);
    step(0, 0, 0, 0, 1, 0);          // tick 2
    chk(!playing, "R4 still holding", int'(playing), 0);
    step(0, 0, 0, 0, 1, 0);          // tick 3
    chk(playing, "R4 playing after third tick", int'(playing), 1);

    // R6: ordered reads, R7: starvation, R8: clear
    step(0, 0, 0, 1, 0, 0);
    chk(slot_valid && slot_data == 16'h0A01, "R6 first packet", int'(slot_data), 16'h0A01);
    step(0, 0, 0, 1, 0, 0);
    chk(slot_data == 16'h0A02, "R6 second packet", int'(slot_data), 16'h0A02);
    step(0, 0, 0, 1, 0, 0);
    chk(slot_starved && slot_data == 16'hFFFF && fill_level == 0, "R7 starved slot",
        int'(slot_data), 16'hFFFF);
    idle(3);
    chk(unf_flag, "R8 underrun sticky", int'(unf_flag), 1);
    step(0, 0, 0, 1, 0, 1);          // new starvation with clear: set wins
    chk(unf_flag, "R8 set wins over clear", int'(unf_flag), 1);
    step(0, 0, 0, 0, 0, 1);
    chk(!unf_flag, "R8 cleared", int'(unf_flag), 0);

    // R3: overflow keeps stored contents
    for (int i = 0; i < DEPTH + 2; i++) step(0, 1, 16'h0B00 + i, 0, 0, 0);
    chk(ovf_flag && fill_level == DEPTH, "R3 overflow drop", int'(fill_level), DEPTH);
    step(0, 1, 16'h0BFF, 1, 0, 0);   // full + read + write: write dropped
    chk(fill_level == DEPTH - 1, "R3 full judged before read", int'(fill_level), DEPTH - 1);
    for (int i = 0; i < DEPTH - 1; i++) step(0, 0, 0, 1, 0, 0);
    chk(slot_data == 16'h0B07, "R3 last stored packet intact", int'(slot_data), 16'h0B07);

    // R9: context reset re-arms the delay
    step(0, 1, 16'h0C01, 0, 0, 0);
    step(1, 1, 16'h0C02, 1, 0, 0);
    chk(fill_level == 0 && !playing && ovf_flag, "R9 clear empties, flags kept",
        int'(fill_level), 0);
    start_frames = 8'd2;
    step(0, 1, 16'h0C03, 0, 0, 0);
    step(0, 0, 0, 0, 1, 0);
    chk(!playing, "R9 rearmed delay holds", int'(playing), 0);
    step(0, 0, 0, 0, 1, 0);
    chk(playing, "R9 rearmed delay expires", int'(playing), 1);

    // R4: zero delay starts at once
    step(1, 0, 0, 0, 0, 1);
    start_frames = 8'd0;
    step(0, 1, 16'h0D01, 0, 0, 0);
    chk(playing, "R4 zero delay", int'(playing), 1);

    // Random traffic
    for (int i = 0; i < 4000; i++) begin
      if (i % 500 == 0) start_frames = FRAME_W'($urandom_range(0, 4));
      step(($urandom_range(0, 199) == 0),
           ($urandom_range(0, 99) < 45),
           int'($urandom_range(0, 65535)),
           ($urandom_range(0, 99) < 40),
           ($urandom_range(0, 99) < 10),
           ($urandom_range(0, 99) < 5));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule